// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block changes the divider settings of one analog PLL without handing an unstable clock to the logic downstream. A single-cycle start pulse carries the requested input divider, feedback multiplier and output divider. The sequencer then steps the PLL through a fixed order. First it selects the slow bypass mode and asserts the PLL reset. Next it writes the three divider fields, then the loop bandwidth field. It then releases reset and waits for the lock indication. Once lock is seen it switches the PLL to normal mode.

Each divider field holds its value minus one. The bandwidth field holds half of the feedback multiplier, minus one. A readback output computes the resulting output frequency in whole MHz from the programmed fields and the reference frequency. A lock window counter bounds the wait for lock. If lock does not arrive in time, the sequence ends with an error and the PLL stays in slow mode. A request that contains a zero divider is refused at once and changes nothing.

Top module: `pll_prog_seq`

## Requirements
- R1: When start is seen while idle and NR, NF and NO are all nonzero, the next cycle shows mode = slow (2'b00) and PLL reset high together, with busy high and the divider fields not yet changed.
- R2: One cycle after R1, the NR, NF and NO fields show the requested values minus one, while the bandwidth field still holds its previous value.
- R3: One cycle after R2, the bandwidth field shows (NF >> 1) - 1 modulo 2^BW_W (so NF = 1 gives all ones), with reset still high.
- R4: One cycle after R3, PLL reset goes low, and mode stays slow.
- R5: After reset is released, mode becomes normal (2'b01) in the cycle after the lock input is first seen high. A done pulse lasting one cycle comes with it, and busy falls at the same time.
- R6: The rate output equals REF_MHZ * (NF field + 1) / ((NR field + 1) * (NO field + 1)), using integer division, in MHz.
- R7: If lock stays low for LOCK_TIMEOUT cycles after reset release, a one-cycle error pulse ends the sequence. Mode stays slow and busy falls.
- R8: A start pulse that arrives while busy is high is ignored. The sequence runs to completion with the first request's fields.
- R9: A start request with NR, NF or NO equal to zero raises error in the next cycle, keeps busy low, and leaves mode, reset and all fields unchanged.
- R10: After reset: mode slow, PLL reset low, all fields zero, busy, done and error low, and the rate output equals REF_MHZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| nr_i | input | NR_W | Requested input divider value |
| nf_i | input | NF_W | Requested feedback multiplier value |
| no_i | input | NO_W | Requested output divider value |
| pll_lock_i | input | 1 | Lock status from the PLL |
| pll_mode_o | output | 2 | PLL mode: 2'b00 slow, 2'b01 normal |
| pll_reset_o | output | 1 | PLL reset |
| pll_nr_o | output | NR_W | Input divider field (value - 1) |
| pll_nf_o | output | NF_W | Feedback multiplier field (value - 1) |
| pll_no_o | output | NO_W | Output divider field (value - 1) |
| pll_bwadj_o | output | BW_W | Loop bandwidth field |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: locked and in normal mode |
| error_o | output | 1 | One-cycle pulse: lock timeout or rejected request |
| rate_mhz_o | output | RATE_W | Output rate computed from the fields, in MHz |

## Verification
The bench builds the block with LOCK_TIMEOUT set to 40 cycles, so a lock that never arrives ends the run quickly and the exact timeout cycle can be checked. The divider widths stay at their defaults of 6, 12 and 4 bits. This lets the table reach the largest legal values of every field, and NF = 1, where the bandwidth field wraps to all ones. The modelled lock delays run from 0 to 12 cycles after reset release, which covers a lock in the very first waiting cycle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_BW,
    ST_REL,
    ST_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_SLOW   = 2'b00,
    MODE_NORMAL = 2'b01
  } pll_mode_t;

  // Output rate in MHz from stored fields (each field is value - 1).
  function automatic int unsigned rate_from_fields(input int unsigned ref_mhz,
                                                   input int unsigned nr_f,
                                                   input int unsigned nf_f,
                                                   input int unsigned no_f);
    int unsigned num;
    int unsigned den;
    num = ref_mhz * (nf_f + 1);
    den = (nr_f + 1) * (no_f + 1);
    return num / den;
  endfunction

endpackage

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic req_zero_i,
  input  logic lock_i,
  input  logic expired_i,
  output logic accept_o,
  output logic reject_o,
  output logic step_div_o,
  output logic step_bw_o,
  output logic step_rel_o,
  output logic waiting_o,
  output logic step_lock_o,
  output logic step_fail_o,
  output logic busy_o,
  output logic done_o,
  output logic error_o
);

  seq_state_t state_q;
  logic       idle;

  assign idle        = (state_q == ST_IDLE);
  assign accept_o    = idle && start_i && !req_zero_i;
  assign reject_o    = idle && start_i && req_zero_i;
  assign step_div_o  = (state_q == ST_DIV);
  assign step_bw_o   = (state_q == ST_BW);
  assign step_rel_o  = (state_q == ST_REL);
  assign waiting_o   = (state_q == ST_WAIT);
  assign step_lock_o = waiting_o && lock_i;
  assign step_fail_o = waiting_o && !lock_i && expired_i;
  assign busy_o      = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      done_o  <= step_lock_o;
      error_o <= step_fail_o || reject_o;
      case (state_q)
        ST_IDLE: if (accept_o) state_q <= ST_DIV;
        ST_DIV:  state_q <= ST_BW;
        ST_BW:   state_q <= ST_REL;
        ST_REL:  state_q <= ST_WAIT;
        ST_WAIT: if (step_lock_o || step_fail_o) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  ignore_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !step_lock_o && !step_fail_o) |=> busy_o);

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned LOCK_TIMEOUT = 100000,
  localparam int unsigned TO_W = $clog2(LOCK_TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);

  logic [TO_W-1:0] cnt_q;

  assign expired_o = (cnt_q == TO_W'(LOCK_TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (run_i && !expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TO_W'(LOCK_TIMEOUT - 1));

endmodule

// File: rtl/pll_seq_fields.sv
module pll_seq_fields
  import pll_seq_pkg::*;
#(
  parameter int unsigned NR_W = 6,
  parameter int unsigned NF_W = 12,
  parameter int unsigned NO_W = 4,
  parameter int unsigned BW_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic            step_div_i,
  input  logic            step_bw_i,
  input  logic            step_rel_i,
  input  logic            step_lock_i,
  input  logic [NR_W-1:0] nr_i,
  input  logic [NF_W-1:0] nf_i,
  input  logic [NO_W-1:0] no_i,
  output logic [1:0]      mode_o,
  output logic            reset_o,
  output logic [NR_W-1:0] nr_o,
  output logic [NF_W-1:0] nf_o,
  output logic [NO_W-1:0] no_o,
  output logic [BW_W-1:0] bw_o
);

  logic [NR_W-1:0] req_nr_q;
  logic [NF_W-1:0] req_nf_q;
  logic [NO_W-1:0] req_no_q;

  function automatic logic [BW_W-1:0] bw_calc(input logic [NF_W-1:0] nf);
    return BW_W'(nf >> 1) - BW_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_nr_q <= '0;
      req_nf_q <= '0;
      req_no_q <= '0;
      mode_o   <= MODE_SLOW;
      reset_o  <= 1'b0;
      nr_o     <= '0;
      nf_o     <= '0;
      no_o     <= '0;
      bw_o     <= '0;
    end else begin
      if (accept_i) begin
        req_nr_q <= nr_i;
        req_nf_q <= nf_i;
        req_no_q <= no_i;
        mode_o   <= MODE_SLOW;
        reset_o  <= 1'b1;
      end
      if (step_div_i) begin
        nr_o <= req_nr_q - 1'b1;
        nf_o <= req_nf_q - 1'b1;
        no_o <= req_no_q - 1'b1;
      end
      if (step_bw_i) bw_o <= bw_calc(req_nf_q);
      if (step_rel_i) reset_o <= 1'b0;
      if (step_lock_i) mode_o <= MODE_NORMAL;
    end
  end

  // R3
  bw_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_o) |-> (bw_o == bw_calc(nf_o + 1'b1)));

  // R2
  div_under_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(nr_o) || !$stable(nf_o) || !$stable(no_o)) |-> reset_o);

endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned NR_W         = 6,
  parameter int unsigned NF_W         = 12,
  parameter int unsigned NO_W         = 4,
  parameter int unsigned BW_W         = 12,
  parameter int unsigned RATE_W       = 20,
  parameter int unsigned REF_MHZ      = 24,
  parameter int unsigned LOCK_TIMEOUT = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NR_W-1:0]   nr_i,
  input  logic [NF_W-1:0]   nf_i,
  input  logic [NO_W-1:0]   no_i,
  input  logic              pll_lock_i,
  output logic [1:0]        pll_mode_o,
  output logic              pll_reset_o,
  output logic [NR_W-1:0]   pll_nr_o,
  output logic [NF_W-1:0]   pll_nf_o,
  output logic [NO_W-1:0]   pll_no_o,
  output logic [BW_W-1:0]   pll_bwadj_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [RATE_W-1:0] rate_mhz_o
);

  logic req_zero, accept, reject;
  logic step_div, step_bw, step_rel, waiting, step_lock, step_fail;
  logic expired;

  assign req_zero = (nr_i == '0) || (nf_i == '0) || (no_i == '0);

  pll_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .req_zero_i (req_zero),
    .lock_i     (pll_lock_i),
    .expired_i  (expired),
    .accept_o   (accept),
    .reject_o   (reject),
    .step_div_o (step_div),
    .step_bw_o  (step_bw),
    .step_rel_o (step_rel),
    .waiting_o  (waiting),
    .step_lock_o(step_lock),
    .step_fail_o(step_fail),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .error_o    (error_o)
  );

  pll_seq_timer #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (step_rel),
    .run_i    (waiting),
    .expired_o(expired)
  );

  pll_seq_fields #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)) u_fields (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .step_div_i (step_div),
    .step_bw_i  (step_bw),
    .step_rel_i (step_rel),
    .step_lock_i(step_lock),
    .nr_i       (nr_i),
    .nf_i       (nf_i),
    .no_i       (no_i),
    .mode_o     (pll_mode_o),
    .reset_o    (pll_reset_o),
    .nr_o       (pll_nr_o),
    .nf_o       (pll_nf_o),
    .no_o       (pll_no_o),
    .bw_o       (pll_bwadj_o)
  );

  assign rate_mhz_o = RATE_W'(rate_from_fields(REF_MHZ, int'(pll_nr_o),
                                               int'(pll_nf_o), int'(pll_no_o)));

  // R1
  enter_slow_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pll_reset_o && pll_mode_o == MODE_SLOW && busy_o));

  // R5
  normal_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mode_o == MODE_NORMAL && $past(pll_mode_o) != MODE_NORMAL)
      |-> ($past(pll_lock_i) && !pll_reset_o && done_o));

  // R7
  timeout_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fail |=> (error_o && pll_mode_o == MODE_SLOW && !busy_o));

  // R9
  reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (error_o && !busy_o && $stable(pll_nr_o) && $stable(pll_nf_o)
                && $stable(pll_no_o) && $stable(pll_mode_o) && $stable(pll_reset_o)));

endmodule

// File: tb/pll_prog_seq_test.sv
module pll_prog_seq_test;

  localparam int NR_W = 6, NF_W = 12, NO_W = 4, BW_W = 12, RATE_W = 20;
  localparam int REF = 24;
  localparam int TMO = 40;
  localparam int NV  = 9;

  // nr, nf, no, lock delay (delay >= TMO means no lock)
  localparam int V_NR[NV]  = '{1, 12, 1, 1, 2, 3, 1, 63, 1};
  localparam int V_NF[NV]  = '{68, 800, 48, 100, 111, 200, 1, 4095, 50};
  localparam int V_NO[NV]  = '{2, 2, 2, 6, 1, 2, 1, 15, 2};
  localparam int V_DLY[NV] = '{0, 3, 7, 1, 12, 2, 0, 5, 1000};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lock = 1'b0;
  logic [NR_W-1:0] nr = '0;
  logic [NF_W-1:0] nf = '0;
  logic [NO_W-1:0] no = '0;
  logic [1:0] mode;
  logic prst, busy, done, err;
  logic [NR_W-1:0] nr_f;
  logic [NF_W-1:0] nf_f;
  logic [NO_W-1:0] no_f;
  logic [BW_W-1:0] bw_f;
  logic [RATE_W-1:0] rate;

  int total = 0, fails = 0, lock_delay = 0, low_cnt = 0, cycles = 0;

  always #2 clk = ~clk;

  pll_prog_seq #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W),
                 .RATE_W(RATE_W), .REF_MHZ(REF), .LOCK_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .nr_i(nr), .nf_i(nf), .no_i(no),
    .pll_lock_i(lock), .pll_mode_o(mode), .pll_reset_o(prst), .pll_nr_o(nr_f),
    .pll_nf_o(nf_f), .pll_no_o(no_f), .pll_bwadj_o(bw_f), .busy_o(busy),
    .done_o(done), .error_o(err), .rate_mhz_o(rate));

  // PLL lock model: lock follows reset release after lock_delay cycles
  always @(negedge clk) begin
    if (prst) begin
      low_cnt <= 0;
      lock <= 1'b0;
    end else begin
      lock <= (low_cnt >= lock_delay);
      low_cnt <= low_cnt + 1;
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_bw(input int f);
    return ((f >> 1) - 1) & ((1 << BW_W) - 1);
  endfunction

  function automatic int exp_rate(input int r, input int f, input int o);
    return (REF * f) / (r * o);
  endfunction

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic run_seq(input int r, input int f, input int o, input int dly,
                         input bit disturb);
    int p_nr, p_nf, p_no, p_bw, k;
    bit ended;
    p_nr = int'(nr_f); p_nf = int'(nf_f); p_no = int'(no_f); p_bw = int'(bw_f);
    lock_delay = dly;
    nr = NR_W'(r); nf = NF_W'(f); no = NO_W'(o); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "mode slow", int'(mode), 0);
    chk("R1", "reset high", int'(prst), 1);
    chk("R1", "busy", int'(busy), 1);
    chk("R1", "nf field unchanged", int'(nf_f), p_nf);
    if (disturb) begin
      // R8: a second request while busy
      nr = 6'd5; nf = 12'd9; no = 4'd3; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R2", "nr field", int'(nr_f), r - 1);
    chk("R2", "nf field", int'(nf_f), f - 1);
    chk("R2", "no field", int'(no_f), o - 1);
    chk("R2", "bw not yet", int'(bw_f), p_bw);
    @(negedge clk);
    chk("R3", "bw field", int'(bw_f), exp_bw(f));
    chk("R3", "reset held", int'(prst), 1);
    @(negedge clk);
    chk("R4", "reset released", int'(prst), 0);
    chk("R4", "mode slow", int'(mode), 0);
    k = 0;
    ended = 1'b0;
    while (!ended && k < TMO + 5) begin
      @(negedge clk);
      k++;
      if (done || err) ended = 1'b1;
    end
    if (dly < TMO) begin
      chk("R5", "lock wait cycles", k, dly + 1);
      chk("R5", "done", int'(done), 1);
      chk("R5", "mode normal", int'(mode), 1);
      chk("R5", "busy low", int'(busy), 0);
    end else begin
      chk("R7", "timeout cycles", k, TMO);
      chk("R7", "error", int'(err), 1);
      chk("R7", "mode slow", int'(mode), 0);
      chk("R7", "busy low", int'(busy), 0);
    end
    chk("R6", "rate", int'(rate), exp_rate(r, f, o));
    if (disturb) begin
      chk("R8", "nr kept", int'(nr_f), r - 1);
      chk("R8", "nf kept", int'(nf_f), f - 1);
      chk("R8", "no kept", int'(no_f), o - 1);
    end
    @(negedge clk);
    chk("R5", "done pulse one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "mode", int'(mode), 0);
    chk("R10", "reset", int'(prst), 0);
    chk("R10", "nf field", int'(nf_f), 0);
    chk("R10", "bw field", int'(bw_f), 0);
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "done|error", int'(done | err), 0);
    chk("R10", "rate", int'(rate), REF);

    for (int i = 0; i < NV; i++) begin
      run_seq(V_NR[i], V_NF[i], V_NO[i], V_DLY[i], 1'b0);
      repeat (2) @(negedge clk);
    end

    // R8 start while busy
    run_seq(2, 111, 1, 4, 1'b1);
    repeat (2) @(negedge clk);

    // R9 zero rejection, one case per field
    for (int z = 0; z < 3; z++) begin
      int p_nf, p_mode;
      p_nf = int'(nf_f);
      p_mode = int'(mode);
      nr = (z == 0) ? '0 : 6'd3;
      nf = (z == 1) ? '0 : 12'd40;
      no = (z == 2) ? '0 : 4'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9", "error", int'(err), 1);
      chk("R9", "busy", int'(busy), 0);
      chk("R9", "nf field", int'(nf_f), p_nf);
      chk("R9", "mode", int'(mode), p_mode);
      chk("R9", "reset", int'(prst), 0);
      @(negedge clk);
      chk("R9", "error one cycle", int'(err), 0);
    end

    finish_run();
  end

endmodule